// File: doc/BRIEF.md
# Triple-Core Store Voter with Duplex Fallback

This unit sits between three redundant cores that run the same thread and the memory system's write path. Each core hands over its store results (address, data, byte enables) through its own valid/ready channel. Only stores take part in the comparison. No other result leaves the cores. Once every active core has delivered its store, the unit forms the store that memory sees and offers it on a single valid/ready commit channel.

In triple mode the committed store is the bitwise majority of the three copies, so a single upset in one core is masked. The core whose copy differs in any field is recorded as faulty, and the unit falls back to a duplex mode. In duplex mode the two remaining cores are compared and nothing is masked. A mismatch there raises a detection pulse and the store is dropped. If all three copies differ in triple mode, nothing is committed and an uncorrectable pulse is raised. Only a reset or a configuration restore pulse brings triple mode back.

Back-pressure rules: a core channel accepts one store and then holds ready low until that store has been resolved. The commit channel holds its valid and payload steady while the downstream ready is low. Core-side inputs need no stability while their ready is low.

Top module: `store_vote_unit`

## Requirements
- R1: An active core's `core_ready` is high exactly while that core has no store pending. `commit_valid` stays low until every active core has delivered its store. While a triple-mode commit is pending, all three readies are low.
- R2: When all three copies agree in triple mode, the commit channel carries that common address, data and byte enables, and no fault pulse is raised.
- R3: When exactly one copy differs in any field in triple mode, the committed store equals the matching pair. `masked_fault` pulses high for the one cycle that follows the commit handshake. At most one of the three fault pulses is high in any cycle.
- R4: In the same case, from the cycle after the commit `mode_dual` reads 1 and `bad_core` holds the index (0, 1 or 2) of the differing core. `bad_core` reads 0 in triple mode and never reads 3.
- R5: In duplex mode the excluded core's `core_ready` stays high, and its valid and payload have no effect on what is committed.
- R6: In duplex mode, a difference between the two remaining copies commits nothing. `fault_detected` pulses for one cycle, the pending stores are dropped and the unit stays in duplex mode.
- R7: In triple mode, when all three copies differ pairwise, nothing is committed. `uncorrectable` pulses for one cycle, the pending stores are dropped and the unit stays in triple mode.
- R8: A high `cfg_restore` in a cycle discards all pending stores. From the next cycle the unit is in triple mode with `bad_core` at 0. It takes priority over any status change in that same cycle.
- R9: While `commit_valid` is high and `commit_ready` is low, the next cycle keeps `commit_valid` high with the same address, data and byte enables.
- R10: After reset the unit is in triple mode, all core readies are high, `commit_valid` is low and no fault pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_valid | input | 3 | Per-core store valid, bit i for core i |
| core_ready | output | 3 | Per-core store ready, bit i for core i |
| core_addr | input | 3*ADDR_W | Store addresses, core i in bits [i*ADDR_W +: ADDR_W] |
| core_data | input | 3*DATA_W | Store data, core i in bits [i*DATA_W +: DATA_W] |
| core_be | input | 3*DATA_W/8 | Byte enables, core i in bits [i*DATA_W/8 +: DATA_W/8] |
| commit_valid | output | 1 | Resolved store available |
| commit_ready | input | 1 | Downstream accepts the resolved store |
| commit_addr | output | ADDR_W | Resolved store address |
| commit_data | output | DATA_W | Resolved store data |
| commit_be | output | DATA_W/8 | Resolved byte enables |
| cfg_restore | input | 1 | Configuration pulse: discard pending stores and return to triple mode |
| mode_dual | output | 1 | 0 = triple voting, 1 = duplex detection |
| bad_core | output | 2 | Index of the excluded core, 0 in triple mode |
| masked_fault | output | 1 | One-cycle pulse: a single-core upset was outvoted |
| fault_detected | output | 1 | One-cycle pulse: duplex mismatch, store dropped |
| uncorrectable | output | 1 | One-cycle pulse: three-way disagreement, store dropped |

## Verification
The assertions assume a downstream that follows the valid/ready contract. They also assume `cfg_restore` is a synchronous pulse. They make no assumption that cores hold their payload while ready is low, because the unit captures each store on its handshake. The bench drives every core input and `cfg_restore` only at falling edges, and it raises a core's valid only for one cycle at a time. It stalls the commit channel only by holding `commit_ready` low over whole cycles, so every stimulus stays inside the handshake rules the checker relies on.

// File: rtl/svu_pkg.sv
package svu_pkg;

  localparam int unsigned NUM_CORES = 3;

  typedef enum logic {
    MODE_TRIPLE = 1'b0,
    MODE_DUAL   = 1'b1
  } svu_mode_e;

  typedef enum logic [1:0] {
    VERDICT_AGREE    = 2'd0,
    VERDICT_MASKED   = 2'd1,
    VERDICT_MISMATCH = 2'd2,
    VERDICT_SPLIT    = 2'd3
  } svu_verdict_e;

endpackage

// File: rtl/svu_slot.sv
module svu_slot #(
  parameter int unsigned W = 68
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (clear) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
      dout <= din;
    end
  end

endmodule

// File: rtl/svu_vote.sv
module svu_vote
  import svu_pkg::*;
#(
  parameter int unsigned W = 68
) (
  input  logic [W-1:0]  in0,
  input  logic [W-1:0]  in1,
  input  logic [W-1:0]  in2,
  input  logic          dual,
  input  logic [1:0]    excluded,
  output svu_verdict_e  verdict,
  output logic [1:0]    culprit,
  output logic [W-1:0]  result
);

  logic eq01, eq02, eq12;
  logic [W-1:0] majority;

  assign eq01 = (in0 == in1);
  assign eq02 = (in0 == in2);
  assign eq12 = (in1 == in2);

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign majority[b] = (in0[b] & in1[b]) | (in0[b] & in2[b]) | (in1[b] & in2[b]);
    end
  endgenerate

  always_comb begin
    verdict = VERDICT_AGREE;
    culprit = 2'd0;
    result  = majority;
    if (dual) begin
      unique case (excluded)
        2'd0: begin
          result  = in1;
          verdict = eq12 ? VERDICT_AGREE : VERDICT_MISMATCH;
        end
        2'd1: begin
          result  = in0;
          verdict = eq02 ? VERDICT_AGREE : VERDICT_MISMATCH;
        end
        default: begin
          result  = in0;
          verdict = eq01 ? VERDICT_AGREE : VERDICT_MISMATCH;
        end
      endcase
    end else if (eq01 && eq02) begin
      verdict = VERDICT_AGREE;
    end else if (eq01) begin
      verdict = VERDICT_MASKED;
      culprit = 2'd2;
    end else if (eq02) begin
      verdict = VERDICT_MASKED;
      culprit = 2'd1;
    end else if (eq12) begin
      verdict = VERDICT_MASKED;
      culprit = 2'd0;
    end else begin
      verdict = VERDICT_SPLIT;
    end
  end

endmodule

// File: rtl/svu_ctrl.sv
module svu_ctrl
  import svu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         all_full,
  input  svu_verdict_e verdict,
  input  logic [1:0]   culprit,
  input  logic         commit_ready,
  input  logic         cfg_restore,
  output logic         commit_ok,
  output logic         resolve,
  output logic         mode_dual,
  output logic [1:0]   bad_core,
  output logic         masked_fault,
  output logic         fault_detected,
  output logic         uncorrectable
);

  svu_mode_e mode_q;
  logic      drop;

  assign commit_ok = all_full && (verdict == VERDICT_AGREE || verdict == VERDICT_MASKED);
  assign drop      = all_full && (verdict == VERDICT_MISMATCH || verdict == VERDICT_SPLIT);
  assign resolve   = (commit_ok && commit_ready) || drop;
  assign mode_dual = (mode_q == MODE_DUAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q         <= MODE_TRIPLE;
      bad_core       <= 2'd0;
      masked_fault   <= 1'b0;
      fault_detected <= 1'b0;
      uncorrectable  <= 1'b0;
    end else begin
      masked_fault   <= 1'b0;
      fault_detected <= 1'b0;
      uncorrectable  <= 1'b0;
      if (cfg_restore) begin
        mode_q   <= MODE_TRIPLE;
        bad_core <= 2'd0;
      end else if (resolve) begin
        unique case (verdict)
          VERDICT_MASKED: begin
            mode_q       <= MODE_DUAL;
            bad_core     <= culprit;
            masked_fault <= 1'b1;
          end
          VERDICT_MISMATCH: fault_detected <= 1'b1;
          VERDICT_SPLIT:    uncorrectable  <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/store_vote_unit.sv
module store_vote_unit
  import svu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CORES-1:0]          core_valid,
  output logic [NUM_CORES-1:0]          core_ready,
  input  logic [NUM_CORES*ADDR_W-1:0]   core_addr,
  input  logic [NUM_CORES*DATA_W-1:0]   core_data,
  input  logic [NUM_CORES*DATA_W/8-1:0] core_be,
  output logic                          commit_valid,
  input  logic                          commit_ready,
  output logic [ADDR_W-1:0]             commit_addr,
  output logic [DATA_W-1:0]             commit_data,
  output logic [DATA_W/8-1:0]           commit_be,
  input  logic                          cfg_restore,
  output logic                          mode_dual,
  output logic [1:0]                    bad_core,
  output logic                          masked_fault,
  output logic                          fault_detected,
  output logic                          uncorrectable
);

  localparam int unsigned BE_W = DATA_W / 8;
  localparam int unsigned ST_W = ADDR_W + DATA_W + BE_W;

  logic [NUM_CORES-1:0] active, full;
  logic [ST_W-1:0]      slot_q [NUM_CORES];
  logic                 all_full, commit_ok, resolve;
  svu_verdict_e         verdict;
  logic [1:0]           culprit;
  logic [ST_W-1:0]      result;

  genvar c;
  generate
    for (c = 0; c < NUM_CORES; c++) begin : g_core
      logic [ST_W-1:0] din;
      assign active[c]     = !(mode_dual && (bad_core == 2'(c)));
      assign core_ready[c] = !active[c] || !full[c];
      assign din = {core_addr[c*ADDR_W +: ADDR_W],
                    core_data[c*DATA_W +: DATA_W],
                    core_be[c*BE_W +: BE_W]};
      svu_slot #(.W(ST_W)) i_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (core_valid[c] && core_ready[c] && active[c]),
        .clear (resolve || cfg_restore || !active[c]),
        .din   (din),
        .full  (full[c]),
        .dout  (slot_q[c])
      );
    end
  endgenerate

  assign all_full = &(full | ~active);

  svu_vote #(.W(ST_W)) i_vote (
    .in0      (slot_q[0]),
    .in1      (slot_q[1]),
    .in2      (slot_q[2]),
    .dual     (mode_dual),
    .excluded (bad_core),
    .verdict  (verdict),
    .culprit  (culprit),
    .result   (result)
  );

  svu_ctrl i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .all_full       (all_full),
    .verdict        (verdict),
    .culprit        (culprit),
    .commit_ready   (commit_ready),
    .cfg_restore    (cfg_restore),
    .commit_ok      (commit_ok),
    .resolve        (resolve),
    .mode_dual      (mode_dual),
    .bad_core       (bad_core),
    .masked_fault   (masked_fault),
    .fault_detected (fault_detected),
    .uncorrectable  (uncorrectable)
  );

  assign commit_valid = commit_ok;
  assign {commit_addr, commit_data, commit_be} = result;

endmodule

// File: rtl/svu_checker.sv
module svu_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          core_ready,
  input logic                commit_valid,
  input logic                commit_ready,
  input logic [ADDR_W-1:0]   commit_addr,
  input logic [DATA_W-1:0]   commit_data,
  input logic [DATA_W/8-1:0] commit_be,
  input logic                cfg_restore,
  input logic                mode_dual,
  input logic [1:0]          bad_core,
  input logic                masked_fault,
  input logic                fault_detected,
  input logic                uncorrectable
);

  AST_TRIPLE_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_dual && commit_valid) |-> (core_ready == 3'b000)); // R1

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({masked_fault, fault_detected, uncorrectable})); // R3

  AST_MASK_MEANS_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    masked_fault |-> mode_dual); // R4

  AST_BAD_INDEX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_core != 2'd3) && (mode_dual || bad_core == 2'd0)); // R4

  AST_EXCLUDED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_dual |-> core_ready[bad_core]); // R5

  AST_DUAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dual && !cfg_restore) |=> mode_dual); // R6

  AST_SPLIT_ONLY_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> !mode_dual); // R7

  AST_RESTORE_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_restore |=> (!mode_dual && bad_core == 2'd0)); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready && !cfg_restore) |=>
      (commit_valid && $stable(commit_addr) && $stable(commit_data) && $stable(commit_be))); // R9

endmodule

bind store_vote_unit svu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_svu_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_ready     (core_ready),
  .commit_valid   (commit_valid),
  .commit_ready   (commit_ready),
  .commit_addr    (commit_addr),
  .commit_data    (commit_data),
  .commit_be      (commit_be),
  .cfg_restore    (cfg_restore),
  .mode_dual      (mode_dual),
  .bad_core       (bad_core),
  .masked_fault   (masked_fault),
  .fault_detected (fault_detected),
  .uncorrectable  (uncorrectable)
);

// File: tb/test_store_vote_unit.sv
`timescale 1ns/1ps
module test_store_vote_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  core_valid = '0;
  logic [2:0]  core_ready;
  logic [31:0] b_addr [3];
  logic [31:0] b_data [3];
  logic [3:0]  b_be   [3];
  logic [95:0] core_addr;
  logic [95:0] core_data;
  logic [11:0] core_be;
  logic        commit_valid, commit_ready = 1'b1;
  logic [31:0] commit_addr, commit_data;
  logic [3:0]  commit_be;
  logic        cfg_restore = 1'b0;
  logic        mode_dual;
  logic [1:0]  bad_core;
  logic        masked_fault, fault_detected, uncorrectable;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        got_cv;
  logic [67:0] got_pl;
  logic [2:0]  got_ready;
  logic [2:0]  got_flags;
  logic        got_dual;
  logic [1:0]  got_bad;

  assign core_addr = {b_addr[2], b_addr[1], b_addr[0]};
  assign core_data = {b_data[2], b_data[1], b_data[0]};
  assign core_be   = {b_be[2], b_be[1], b_be[0]};

  always #2.5 clk = ~clk;

  store_vote_unit i_store_vote_unit (
    .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
    .core_addr(core_addr), .core_data(core_data), .core_be(core_be),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .commit_addr(commit_addr), .commit_data(commit_data), .commit_be(commit_be),
    .cfg_restore(cfg_restore), .mode_dual(mode_dual), .bad_core(bad_core),
    .masked_fault(masked_fault), .fault_detected(fault_detected),
    .uncorrectable(uncorrectable)
  );

  // vector: {addr, data, be}
  localparam logic [67:0] VEC [5] = '{
    {32'h0000_1000, 32'hDEAD_BEEF, 4'hF},
    {32'h8000_0004, 32'h0000_0001, 4'h1},
    {32'hFFFF_FFFC, 32'hFFFF_FFFF, 4'hC},
    {32'h1234_5678, 32'hA5A5_5A5A, 4'h6},
    {32'h0000_0000, 32'h0000_0000, 4'h0}
  };

  task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_core(input int i, input logic [67:0] st);
    {b_addr[i], b_data[i], b_be[i]} = st;
  endtask

  task automatic set_all(input logic [67:0] st);
    for (int i = 0; i < 3; i++) set_core(i, st);
  endtask

  task automatic fire(input logic [2:0] vmask);
    @(negedge clk); core_valid = vmask;
    @(negedge clk); core_valid = '0;
    got_cv    = commit_valid;
    got_pl    = {commit_addr, commit_data, commit_be};
    got_ready = core_ready;
    @(negedge clk);
    got_flags = {masked_fault, fault_detected, uncorrectable};
    got_dual  = mode_dual;
    got_bad   = bad_core;
  endtask

  task automatic restore();
    @(negedge clk); cfg_restore = 1'b1;
    @(negedge clk); cfg_restore = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [67:0] base, bad;
    set_all('0);
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 ready", 68'(core_ready), 68'(3'b111));
    check("R10 commit_valid", 68'(commit_valid), 68'(0));
    check("R10 mode/flags", 68'({mode_dual, masked_fault, fault_detected, uncorrectable}), 68'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R2: agreeing stores from the table
    foreach (VEC[v]) begin
      set_all(VEC[v]);
      fire(3'b111);
      check("R2 commit_valid", 68'(got_cv), 68'(1));
      check("R2 payload", got_pl, VEC[v]);
      check("R2 no flags", 68'(got_flags), 68'(0));
      check("R1 all readies low while pending", 68'(got_ready), 68'(3'b000));
    end

    // R1: partial arrival holds the commit back
    set_all(VEC[0]);
    @(negedge clk); core_valid = 3'b011;
    @(negedge clk); core_valid = '0;
    check("R1 no commit with core2 missing", 68'(commit_valid), 68'(0));
    check("R1 ready only for core2", 68'(core_ready), 68'(3'b100));
    fire(3'b100);
    check("R1 commit after last core", 68'(got_cv), 68'(1));
    check("R1 payload", got_pl, VEC[0]);

    // R9: back-pressure
    commit_ready = 1'b0;
    set_all(VEC[3]);
    fire(3'b111);
    check("R9 valid under stall", 68'(got_cv), 68'(1));
    @(negedge clk);
    check("R9 valid held", 68'(commit_valid), 68'(1));
    check("R9 payload held", {commit_addr, commit_data, commit_be}, VEC[3]);
    commit_ready = 1'b1;
    @(negedge clk);
    check("R9 released", 68'(commit_valid), 68'(0));

    // R3 R4 R5 R6 R8: an upset in each core position
    for (int k = 0; k < 3; k++) begin
      base = VEC[k + 1];
      bad  = base ^ ((k == 0) ? {32'h0000_0100, 36'h0} :
                     (k == 1) ? {32'h0, 32'h8000_0000, 4'h0} : 68'h1);
      set_all(base);
      set_core(k, bad);
      fire(3'b111);
      check($sformatf("R3 core%0d upset masked payload", k), got_pl, base);
      check("R3 commit_valid", 68'(got_cv), 68'(1));
      check("R3 masked pulse only", 68'(got_flags), 68'(3'b100));
      check("R4 dual mode", 68'(got_dual), 68'(1));
      check("R4 bad core index", 68'(got_bad), 68'(k));
      @(negedge clk);
      check("R3 pulse is one cycle", 68'(masked_fault), 68'(0));

      // R5: excluded core sends garbage, ignored
      set_all(VEC[4]);
      set_core(k, 68'hF_FFFF_FFFF_FFFF_FFFF);
      fire(3'b111);
      check("R5 commit from healthy pair", got_pl, VEC[4]);
      check("R5 commit_valid", 68'(got_cv), 68'(1));
      check("R5 excluded ready high", 68'(got_ready[k]), 68'(1));
      check("R5 no flags", 68'(got_flags), 68'(0));

      // R6: duplex mismatch between the healthy cores
      set_all(VEC[0]);
      set_core((k + 1) % 3, VEC[2]);
      fire(3'b111);
      check("R6 no commit", 68'(got_cv), 68'(0));
      check("R6 detect pulse", 68'(got_flags), 68'(3'b010));
      check("R6 still dual", 68'({got_dual, got_bad}), 68'({1'b1, 2'(k)}));
      set_all(VEC[1]);
      fire(3'b111);
      check("R6 dropped stores not reused", got_pl, VEC[1]);

      // R8: restore
      restore();
      check("R8 triple mode", 68'({mode_dual, bad_core}), 68'(0));
    end

    // R7: three-way disagreement
    set_all(VEC[1]);
    set_core(1, VEC[2]);
    set_core(2, VEC[3]);
    fire(3'b111);
    check("R7 no commit", 68'(got_cv), 68'(0));
    check("R7 uncorrectable pulse", 68'(got_flags), 68'(3'b001));
    check("R7 stays triple", 68'(got_dual), 68'(0));
    set_all(VEC[2]);
    fire(3'b111);
    check("R7 next store normal", got_pl, VEC[2]);

    // R8: restore discards a pending partial store
    set_all(VEC[3]);
    @(negedge clk); core_valid = 3'b001;
    @(negedge clk); core_valid = '0;
    restore();
    check("R8 pending discarded ready", 68'(core_ready), 68'(3'b111));
    fire(3'b110);
    check("R8 no commit from stale slot", 68'(got_cv), 68'(0));
    set_core(0, VEC[3]);
    fire(3'b001);
    check("R8 commit after fresh store", got_pl, VEC[3]);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule